// File: doc/BRIEF.md
# FIFO Depth-Chain Token Controller

This block is the control core of one FIFO device that can be linked with identical devices to form a deeper FIFO. Each device keeps a write-ownership token and a read-ownership token. A device accepts a write only while it owns the write token and accepts a read only while it owns the read token. When it stores into, or drains from, its last physical slot, it hands the matching token to the next device with a one-cycle pulse. The memory array lies outside this block. The block drives the array's write and read addresses and enables.

A static mode input picks one of two modes. In solo mode (`chain_en` low) the device always owns both tokens. The expansion inputs are ignored, and `wx_out` carries a half-full indication. In chained mode (`chain_en` high) the token logic is active. `first_n` low marks the device that starts with both tokens. Every device's `wx_out`/`rx_out` feeds the `wx_in`/`rx_in` of the next device, and the last device feeds the first. The whole chain runs on one clock.

Both data sides use valid/ready. On the write side the producer raises `wr_valid`. The block raises `wr_ready` when it owns the write token and is not full. A word is stored in the cycle where both are high, and `wr_fire` marks that cycle. On the read side the block raises `rd_valid` when it owns the read token and is not empty. The consumer raises `rd_ready`, and a slot is drained in the cycle where both are high (`rd_fire`). Neither `wr_ready` nor `rd_valid` depends on the other side's handshake input in the same cycle. A producer may hold `wr_valid` high indefinitely while the device lacks the token.

Top module: `fifo_chain_ctl`

## Requirements
- R1: After reset both addresses are 0 and `wx_out`/`rx_out` are low. In chained mode a device with `first_n` low owns both tokens, and a device with `first_n` high owns neither.
- R2: In chained mode `wr_ready` is high only while the device owns the write token and is not full. A write offered without the token is ignored and `wr_addr` holds its value.
- R3: In chained mode, an accepted write at address DEPTH-1 raises `wx_out` for exactly one cycle, starting after that clock edge. The write token is released at the same edge.
- R4: In chained mode, `wx_in` high at a rising edge gives the device the write token from the next cycle on.
- R5: In chained mode `rd_valid` is high only while the device owns the read token and is not empty. A read attempted without the token is ignored and `rd_addr` holds its value.
- R6: In chained mode, an accepted read at address DEPTH-1 raises `rx_out` for exactly one cycle, starting after that clock edge. The read token is released at the same edge.
- R7: In chained mode, `rx_in` high at a rising edge gives the device the read token from the next cycle on.
- R8: In solo mode the device owns both tokens whatever the value of `first_n`. `wx_in` and `rx_in` have no effect, `rx_out` stays low, and wrapping past the last slot releases no token.
- R9: In solo mode `wx_out` is high exactly while the stored word count is greater than DEPTH/2.
- R10: `wr_ready` is low while DEPTH words are stored, and `rd_valid` is low while no word is stored.
- R11: Each accepted transfer advances its address by one, and DEPTH-1 wraps to 0. Without a transfer the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_en | input | 1 | 1 = chained mode, 0 = solo mode (static) |
| first_n | input | 1 | Low on the device that starts with both tokens |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | Device can store a word this cycle |
| wr_fire | output | 1 | Write enable to the array |
| wr_addr | output | $clog2(DEPTH) | Array write address |
| rd_ready | input | 1 | Consumer takes a word |
| rd_valid | output | 1 | Device can supply a word this cycle |
| rd_fire | output | 1 | Read enable to the array |
| rd_addr | output | $clog2(DEPTH) | Array read address |
| wx_in | input | 1 | Write-token pulse from the previous device |
| wx_out | output | 1 | Write-token pulse (chained) or above-half flag (solo) |
| rx_in | input | 1 | Read-token pulse from the previous device |
| rx_out | output | 1 | Read-token pulse (chained), low in solo mode |
| write_own | output | 1 | Device owns the write token |
| read_own | output | 1 | Device owns the read token |

## Verification
A chained first device is driven through one scripted sequence. It fills up to its last slot, releases the write token, refuses writes while it lacks the token, regains the token from a `wx_in` pulse, reaches full, and then drains the same way on the read side. This separates a token that is released, or taken back, one cycle early or late from a correct handover. A non-first chained device is checked to refuse traffic until its inputs pulse. A solo device is filled and drained across the half-way point while its expansion inputs are held high. This shows that the half-full threshold is strict, and that wrapping in solo mode neither pulses nor drops ownership.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  typedef enum logic {
    LINK_SOLO  = 1'b0,
    LINK_CHAIN = 1'b1
  } link_mode_e;
endpackage

// File: rtl/fifo_chain_token.sv
module fifo_chain_token #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       chained,
  input  logic                       start_own,
  input  logic                       room,
  input  logic                       req,
  output logic                       grant,
  output logic                       fire,
  output logic [$clog2(DEPTH)-1:0]   ptr,
  input  logic                       pass_in,
  output logic                       pass_out,
  output logic                       own
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;
  logic          own_q;
  logic          pulse_q;
  logic          at_last;
  logic          hand_off;

  assign own      = chained ? own_q : 1'b1;
  assign grant    = own & room;
  assign fire     = req & grant;
  assign at_last  = (ptr_q == LAST);
  assign hand_off = chained & fire & at_last;
  assign ptr      = ptr_q;
  assign pass_out = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      own_q   <= start_own;
      pulse_q <= 1'b0;
    end else begin
      if (fire) ptr_q <= at_last ? '0 : ptr_q + 1'b1;
      pulse_q <= hand_off;
      if (hand_off)               own_q <= 1'b0;
      else if (chained & pass_in) own_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fifo_chain_level.sv
module fifo_chain_level #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic full,
  output logic empty,
  output logic above_half
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q;

  assign full       = (cnt_q == CW'(DEPTH));
  assign empty      = (cnt_q == '0);
  assign above_half = (cnt_q > CW'(DEPTH / 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (inc & ~dec) cnt_q <= cnt_q + 1'b1;
    else if (dec & ~inc) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/fifo_chain_ctl.sv
module fifo_chain_ctl #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chain_en,
  input  logic                     first_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  output logic                     wr_fire,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic                     rd_ready,
  output logic                     rd_valid,
  output logic                     rd_fire,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  input  logic                     wx_in,
  output logic                     wx_out,
  input  logic                     rx_in,
  output logic                     rx_out,
  output logic                     write_own,
  output logic                     read_own
);
  import fifo_chain_pkg::*;

  link_mode_e mode;
  logic       chained;
  logic       full, empty, above_half;
  logic       wpulse, rpulse;

  assign mode    = link_mode_e'(chain_en);
  assign chained = (mode == LINK_CHAIN);

  fifo_chain_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .inc(wr_fire), .dec(rd_fire),
    .full(full), .empty(empty), .above_half(above_half)
  );

  fifo_chain_token #(.DEPTH(DEPTH)) u_wtok (
    .clk(clk), .rst_n(rst_n), .chained(chained), .start_own(~first_n),
    .room(~full), .req(wr_valid), .grant(wr_ready), .fire(wr_fire),
    .ptr(wr_addr), .pass_in(wx_in), .pass_out(wpulse), .own(write_own)
  );

  fifo_chain_token #(.DEPTH(DEPTH)) u_rtok (
    .clk(clk), .rst_n(rst_n), .chained(chained), .start_own(~first_n),
    .room(~empty), .req(rd_ready), .grant(rd_valid), .fire(rd_fire),
    .ptr(rd_addr), .pass_in(rx_in), .pass_out(rpulse), .own(read_own)
  );

  assign wx_out = chained ? wpulse : above_half;
  assign rx_out = chained & rpulse;
endmodule

// File: rtl/fifo_chain_ctl_chk.sv
module fifo_chain_ctl_chk #(
  parameter int DEPTH = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     chain_en,
  input logic                     wr_fire,
  input logic [$clog2(DEPTH)-1:0] wr_addr,
  input logic                     rd_fire,
  input logic [$clog2(DEPTH)-1:0] rd_addr,
  input logic                     wx_out,
  input logic                     rx_out,
  input logic                     write_own,
  input logic                     read_own
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R2
  wr_needs_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && wr_fire) |-> write_own);
  // R5
  rd_needs_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && rd_fire) |-> read_own);
  // R3
  wx_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && wr_fire && wr_addr == LAST) |=> (wx_out && !write_own));
  // R3
  wx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && wx_out) |=> !wx_out);
  // R6
  rx_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && rd_fire && rd_addr == LAST) |=> (rx_out && !read_own));
  // R6
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out |=> !rx_out);
  // R8
  solo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_en |-> (!rx_out && write_own && read_own));
  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(wr_addr));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_addr));
  // R11
  wr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == LAST) |=> (wr_addr == '0));
endmodule

bind fifo_chain_ctl fifo_chain_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .chain_en(chain_en),
  .wr_fire(wr_fire), .wr_addr(wr_addr), .rd_fire(rd_fire), .rd_addr(rd_addr),
  .wx_out(wx_out), .rx_out(rx_out), .write_own(write_own), .read_own(read_own)
);

// File: tb/fifo_chain_ctl_tb.sv
module fifo_chain_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chain_en = 1'b1, first_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0, wx_in = 1'b0, rx_in = 1'b0;
  logic wr_ready, wr_fire, rd_valid, rd_fire, wx_out, rx_out, write_own, read_own;
  logic [1:0] wr_addr, rd_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_chain_ctl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .first_n(first_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_fire(rd_fire), .rd_addr(rd_addr),
    .wx_in(wx_in), .wx_out(wx_out), .rx_in(rx_in), .rx_out(rx_out),
    .write_own(write_own), .read_own(read_own)
  );

  // inputs {wr_valid, rd_ready, wx_in, rx_in} ; after edge {wr_addr, rd_addr, write_own, read_own, wx_out, rx_out}
  localparam logic [11:0] VEC [15] = '{
    12'b1100_01_00_1100,  // R2 write
    12'b1100_10_01_1100,  // R2 write + read
    12'b1000_11_01_1100,  // R2 write
    12'b1000_00_01_0110,  // R3 last slot, handoff
    12'b1000_00_01_0100,  // R2 ignored without token
    12'b1010_00_01_1100,  // R4 token returns
    12'b1000_01_01_1100,  // R11 wrap write
    12'b1000_01_01_1100,  // R10 full
    12'b0100_01_10_1100,  // R5 read
    12'b0100_01_11_1100,  // R5 read
    12'b0100_01_00_1001,  // R6 last slot, handoff
    12'b0100_01_00_1000,  // R5 ignored without token
    12'b0101_01_00_1100,  // R7 token returns
    12'b0100_01_01_1100,  // R11 wrap read
    12'b0100_01_01_1100   // R10 empty
  };

  function automatic string vec_req(int i);
    case (i)
      3: return "R3";
      5: return "R4";
      6, 13: return "R11";
      7, 14: return "R10";
      8, 9, 11: return "R5";
      10: return "R6";
      12: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(logic chain, logic first);
    @(negedge clk);
    rst_n = 1'b0;
    chain_en = chain; first_n = first;
    wr_valid = 1'b0; rd_ready = 1'b0; wx_in = 1'b0; rx_in = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    #1;
  endtask

  function automatic int snap();
    return {wr_addr, rd_addr, write_own, read_own, wx_out, rx_out};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 chained first device
    do_reset(1'b1, 1'b0);
    check("R1", snap(), 8'b00_00_1100);
    check("R10", rd_valid, 0);
    for (int i = 0; i < 15; i++) begin
      {wr_valid, rd_ready, wx_in, rx_in} = VEC[i][11:8];
      step();
      check(vec_req(i), snap(), VEC[i][7:0]);
    end

    // R1 chained non-first device
    do_reset(1'b1, 1'b1);
    check("R1", snap(), 8'b00_00_0000);
    wr_valid = 1'b1;
    #1;
    check("R2", wr_ready, 0);
    step();
    check("R2", wr_addr, 0);
    wr_valid = 1'b0;
    wx_in = 1'b1; rx_in = 1'b1;
    step();
    wx_in = 1'b0; rx_in = 1'b0;
    check("R4", write_own, 1);
    check("R7", read_own, 1);

    // R8 solo mode with first_n high
    do_reset(1'b0, 1'b1);
    check("R8", {write_own, read_own}, 2'b11);
    wx_in = 1'b1; rx_in = 1'b1; wr_valid = 1'b1;
    step(); step();
    check("R9", wx_out, 0);
    step();
    check("R9", wx_out, 1);
    step();
    check("R11", wr_addr, 0);
    check("R10", wr_ready, 0);
    check("R8", {rx_out, write_own}, 2'b01);
    wr_valid = 1'b0; rd_ready = 1'b1;
    step();
    check("R9", wx_out, 1);
    step();
    check("R9", wx_out, 0);
    step(); step();
    check("R8", {rd_addr, rx_out, read_own}, 4'b0001);
    check("R10", rd_valid, 0);
    rd_ready = 1'b0; wx_in = 1'b0; rx_in = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule